// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits behind the page load logic of a byte-programmable flash array and watches every byte-load event (address plus data). Command sequences open with a two-byte unlock prefix and then branch on the third byte: arming a protected program, switching identification mode on or off, or an extended branch. The extended branch repeats the prefix and then clears protection or goes on to a boot-block lock byte. Bytes that are not part of a command are passed on as ordinary data loads.

The decoder keeps several mode flags. The write-protect flag and the two boot-block lock flags model nonvolatile state, so reset does not clear them. The identification flag, the arming state and the pending protection changes are volatile. A protection change requested by a command takes effect only when the page logic reports the end of the program cycle that follows. The block also produces a program-permit level for the page being loaded and an erase-permit level for the whole array.

Top module: `unlock_seq_decoder`

## Requirements
- R1: Out of reset `id_active` and `data_load` are 0. At first power-up `wp_active`, `boot_lock_lo` and `boot_lock_hi` are 0, `pgm_permit` is 1 and `erase_permit` is 1.
- R2: Every command opens with data 0xAA at command address 0x5555, then data 0x55 at 0x2AAA. Only address bits 14..0 are compared for the prefix and opcode bytes, so bits 16..15 may hold any value.
- R3: Opcode 0xA0 at 0x5555 after the prefix arms the next page, so `pgm_permit` is 1 until `prog_end`. `wp_active` becomes 1 in the cycle after the next `prog_end` pulse.
- R4: While `wp_active` is 1 and no 0xA0 command has armed the page, `pgm_permit` is 0.
- R5: The prefix, then 0x80@0x5555, then the prefix again, then 0x20@0x5555 arms the page and clears `wp_active` in the cycle after the next `prog_end`.
- R6: Opcode 0x90 at 0x5555 after the prefix sets `id_active`. Opcode 0xF0 at 0x5555 clears it.
- R7: The six-byte extended prefix ending in 0x40@0x5555 followed by 0x00 at full address 0x00000 sets `boot_lock_lo`. Followed instead by 0xFF at full address 0x1FFFF, it sets `boot_lock_hi`. Lock flags never fall.
- R8: A boot block is the lowest or highest 8192 bytes of the address space. `pgm_permit` is 0 while the most recent data byte lies in a locked block, and other addresses are unaffected.
- R9: `erase_permit` is 0 whenever either lock flag is 1.
- R10: A byte that breaks a sequence returns the decoder to idle and counts as a data load. A sequence interrupted this way must be restarted from its first byte.
- R11: Reset keeps `wp_active` and both lock flags, and clears `id_active`, the arming state, pending protection changes and any partial sequence.
- R12: `data_load` pulses for one cycle, one cycle after each byte that is not consumed by a command. Bytes consumed by a command produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the volatile state |
| ld_valid | input | 1 | One-cycle strobe for a byte-load event |
| ld_addr | input | 17 | Address of the byte load |
| ld_data | input | 8 | Data of the byte load |
| prog_end | input | 1 | Pulse marking the end of a program cycle |
| data_load | output | 1 | Pulse for a byte treated as ordinary page data |
| wp_active | output | 1 | Write protection is in force |
| id_active | output | 1 | Identification mode is on |
| boot_lock_lo | output | 1 | Lower boot block is locked |
| boot_lock_hi | output | 1 | Upper boot block is locked |
| pgm_permit | output | 1 | The current page may be programmed |
| erase_permit | output | 1 | Whole-array erase is allowed |

## Verification
The assertions assume that `prog_end` and `ld_valid` are never high in the same cycle. They also assume that neither strobe is high during reset, because a protection change attributed to a program end could otherwise coincide with a new command. The stimulus keeps to this: byte loads and program-end pulses come from separate tasks, each holding its strobe for exactly one cycle, and the two are never interleaved. A behavioural reference model matches every incoming byte against the full list of command sequences, and its flags are compared with the outputs on every cycle.

// File: rtl/ucd_pkg.sv
package ucd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PFX1, ST_PFX2, ST_EXT1, ST_EXT2, ST_EXT3, ST_LOCK
  } seq_st_t;

  localparam logic [14:0] CMD_ADR_A = 15'h5555;
  localparam logic [14:0] CMD_ADR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_A     = 8'hAA;
  localparam logic [7:0]  KEY_B     = 8'h55;
  localparam logic [7:0]  OP_ARM    = 8'hA0;
  localparam logic [7:0]  OP_ID_IN  = 8'h90;
  localparam logic [7:0]  OP_ID_OUT = 8'hF0;
  localparam logic [7:0]  OP_EXT    = 8'h80;
  localparam logic [7:0]  OP_UNPROT = 8'h20;
  localparam logic [7:0]  OP_LOCK   = 8'h40;
  localparam logic [7:0]  LOCK_LO_D = 8'h00;
  localparam logic [7:0]  LOCK_HI_D = 8'hFF;

  function automatic logic key_hit(logic [14:0] a, logic [7:0] d,
                                   logic [14:0] ea, logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction
endpackage

// File: rtl/ucd_seq.sv
module ucd_seq import ucd_pkg::*; #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  output logic              ev_arm_on,
  output logic              ev_arm_off,
  output logic              ev_id_on,
  output logic              ev_id_off,
  output logic              ev_lock_lo,
  output logic              ev_lock_hi,
  output logic              ev_data
);
  seq_st_t st_q, st_n;
  logic [14:0] a15;
  logic        hit_a, hit_b, at_a;

  assign a15   = ld_addr[14:0];
  assign hit_a = key_hit(a15, ld_data, CMD_ADR_A, KEY_A);
  assign hit_b = key_hit(a15, ld_data, CMD_ADR_B, KEY_B);
  assign at_a  = (a15 == CMD_ADR_A);

  always_comb begin
    st_n       = st_q;
    ev_arm_on  = 1'b0;
    ev_arm_off = 1'b0;
    ev_id_on   = 1'b0;
    ev_id_off  = 1'b0;
    ev_lock_lo = 1'b0;
    ev_lock_hi = 1'b0;
    ev_data    = 1'b0;
    if (ld_valid) begin
      st_n    = ST_IDLE;
      ev_data = 1'b1;
      unique case (st_q)
        ST_IDLE: if (hit_a) begin st_n = ST_PFX1; ev_data = 1'b0; end
        ST_PFX1: if (hit_b) begin st_n = ST_PFX2; ev_data = 1'b0; end
        ST_PFX2: if (at_a) begin
          ev_data = 1'b0;
          case (ld_data)
            OP_ARM:    ev_arm_on = 1'b1;
            OP_ID_IN:  ev_id_on  = 1'b1;
            OP_ID_OUT: ev_id_off = 1'b1;
            OP_EXT:    st_n      = ST_EXT1;
            default:   ev_data   = 1'b1;
          endcase
        end
        ST_EXT1: if (hit_a) begin st_n = ST_EXT2; ev_data = 1'b0; end
        ST_EXT2: if (hit_b) begin st_n = ST_EXT3; ev_data = 1'b0; end
        ST_EXT3: if (at_a && ld_data == OP_UNPROT) begin
          ev_arm_off = 1'b1; ev_data = 1'b0;
        end else if (at_a && ld_data == OP_LOCK) begin
          st_n = ST_LOCK; ev_data = 1'b0;
        end
        ST_LOCK: if (ld_addr == '0 && ld_data == LOCK_LO_D) begin
          ev_lock_lo = 1'b1; ev_data = 1'b0;
        end else if (ld_addr == '1 && ld_data == LOCK_HI_D) begin
          ev_lock_hi = 1'b1; ev_data = 1'b0;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_n;
  end

  // R10
  data_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data |=> (st_q == ST_IDLE));
endmodule

// File: rtl/ucd_flags.sv
module ucd_flags #(
  parameter int ADDR_W  = 17,
  parameter int BOOT_SZ = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              prog_end,
  input  logic              ev_arm_on,
  input  logic              ev_arm_off,
  input  logic              ev_id_on,
  input  logic              ev_id_off,
  input  logic              ev_lock_lo,
  input  logic              ev_lock_hi,
  input  logic              ev_data,
  output logic              data_load,
  output logic              wp_active,
  output logic              id_active,
  output logic              boot_lock_lo,
  output logic              boot_lock_hi,
  output logic              pgm_permit,
  output logic              erase_permit
);
  localparam logic [ADDR_W-1:0] LO_TOP  = ADDR_W'(BOOT_SZ);
  localparam logic [ADDR_W-1:0] HI_BASE = ADDR_W'((2**ADDR_W) - BOOT_SZ);

  function automatic logic [1:0] boot_zone(logic [ADDR_W-1:0] a);
    return {a >= HI_BASE, a < LO_TOP};
  endfunction

  // nonvolatile state: power-up value only, untouched by reset
  logic wp_q = 1'b0;
  logic lo_q = 1'b0;
  logic hi_q = 1'b0;
  logic id_q, armed_q, pend_on_q, pend_off_q, dl_q;
  logic [1:0] zone_q;

  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (prog_end && pend_on_q)  wp_q <= 1'b1;
      if (prog_end && pend_off_q) wp_q <= 1'b0;
      if (ev_lock_lo) lo_q <= 1'b1;
      if (ev_lock_hi) hi_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q <= 1'b0; armed_q <= 1'b0; pend_on_q <= 1'b0;
      pend_off_q <= 1'b0; dl_q <= 1'b0; zone_q <= 2'b00;
    end else begin
      dl_q <= ev_data;
      if (ev_data) zone_q <= boot_zone(ld_addr);
      if (ev_id_on)  id_q <= 1'b1;
      if (ev_id_off) id_q <= 1'b0;
      if (prog_end) begin
        armed_q <= 1'b0; pend_on_q <= 1'b0; pend_off_q <= 1'b0;
      end
      if (ev_arm_on)  begin armed_q <= 1'b1; pend_on_q <= 1'b1; pend_off_q <= 1'b0; end
      if (ev_arm_off) begin armed_q <= 1'b1; pend_off_q <= 1'b1; pend_on_q <= 1'b0; end
    end
  end

  assign data_load    = dl_q;
  assign wp_active    = wp_q;
  assign id_active    = id_q;
  assign boot_lock_lo = lo_q;
  assign boot_lock_hi = hi_q;
  assign pgm_permit   = (!wp_q || armed_q) && !(zone_q[0] && lo_q) && !(zone_q[1] && hi_q);
  assign erase_permit = !(lo_q || hi_q);

  // R3
  wp_rise_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wp_q) |-> $past(prog_end));
  // R5
  wp_fall_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wp_q) |-> $past(prog_end));
  // R6
  id_rise_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_q) |-> ($past(ld_valid) && $past(ld_data) == 8'h90));
  // R7
  lock_lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) !$fell(lo_q));
  // R7
  lock_hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) !$fell(hi_q));
  // R12
  data_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_load |-> $past(ld_valid));
endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder #(
  parameter int ADDR_W  = 17,
  parameter int BOOT_SZ = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              prog_end,
  output logic              data_load,
  output logic              wp_active,
  output logic              id_active,
  output logic              boot_lock_lo,
  output logic              boot_lock_hi,
  output logic              pgm_permit,
  output logic              erase_permit
);
  logic ev_arm_on, ev_arm_off, ev_id_on, ev_id_off;
  logic ev_lock_lo, ev_lock_hi, ev_data;

  ucd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
    .ev_arm_on(ev_arm_on), .ev_arm_off(ev_arm_off), .ev_id_on(ev_id_on),
    .ev_id_off(ev_id_off), .ev_lock_lo(ev_lock_lo), .ev_lock_hi(ev_lock_hi),
    .ev_data(ev_data));

  ucd_flags #(.ADDR_W(ADDR_W), .BOOT_SZ(BOOT_SZ)) u_flags (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
    .prog_end(prog_end), .ev_arm_on(ev_arm_on), .ev_arm_off(ev_arm_off),
    .ev_id_on(ev_id_on), .ev_id_off(ev_id_off), .ev_lock_lo(ev_lock_lo),
    .ev_lock_hi(ev_lock_hi), .ev_data(ev_data), .data_load(data_load),
    .wp_active(wp_active), .id_active(id_active), .boot_lock_lo(boot_lock_lo),
    .boot_lock_hi(boot_lock_hi), .pgm_permit(pgm_permit), .erase_permit(erase_permit));
endmodule

// File: tb/unlock_seq_decoder_tb.sv
module unlock_seq_decoder_tb;
  logic clk = 1'b0, rst_n = 1'b0, ld_valid = 1'b0, prog_end = 1'b0;
  logic [16:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic data_load, wp_active, id_active, boot_lock_lo, boot_lock_hi, pgm_permit, erase_permit;
  int n_tests = 0, n_fail = 0;
  bit cmp_en = 0, done = 0;

  always #2 clk = ~clk;

  unlock_seq_decoder u_dut (.*);

  // reference model
  bit m_wp = 0, m_lo = 0, m_hi = 0, m_id = 0, m_armed = 0, m_pon = 0, m_poff = 0, m_dl = 0;
  int m_last_addr = 'h8000;
  logic [24:0] hist[$];

  function automatic int cmd_len(int c);
    return (c < 3) ? 3 : (c == 3) ? 6 : 7;
  endfunction

  function automatic bit step_ok(int c, int i, logic [16:0] a, logic [7:0] d);
    logic [14:0] l;
    l = a[14:0];
    case (i)
      0, 3: return l == 15'h5555 && d == 8'hAA;
      1, 4: return l == 15'h2AAA && d == 8'h55;
      2: return l == 15'h5555 && d == ((c == 0) ? 8'hA0 : (c == 1) ? 8'h90 :
                                       (c == 2) ? 8'hF0 : 8'h80);
      5: return l == 15'h5555 && d == ((c == 3) ? 8'h20 : 8'h40);
      6: return (c == 4) ? (a == 17'h0 && d == 8'h00) : (a == 17'h1FFFF && d == 8'hFF);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_id = 0; m_armed = 0; m_pon = 0; m_poff = 0; m_dl = 0; m_last_addr = 'h8000;
      hist.delete();
    end else begin
      m_dl = 0;
      if (prog_end) begin
        if (m_pon) m_wp = 1;
        if (m_poff) m_wp = 0;
        m_armed = 0; m_pon = 0; m_poff = 0;
      end
      if (ld_valid) begin
        int full; bit part; int n;
        full = -1; part = 0; n = hist.size();
        for (int c = 0; c < 6; c++) begin
          bit ok;
          ok = (n + 1 <= cmd_len(c));
          for (int i = 0; i < n; i++)
            if (ok) ok = step_ok(c, i, hist[i][24:8], hist[i][7:0]);
          if (ok) ok = step_ok(c, n, ld_addr, ld_data);
          if (ok) begin
            if (n + 1 == cmd_len(c)) full = c; else part = 1;
          end
        end
        if (full >= 0) begin
          hist.delete();
          case (full)
            0: begin m_armed = 1; m_pon = 1; m_poff = 0; end
            1: m_id = 1;
            2: m_id = 0;
            3: begin m_armed = 1; m_poff = 1; m_pon = 0; end
            4: m_lo = 1;
            default: m_hi = 1;
          endcase
        end else if (part) begin
          hist.push_back({ld_addr, ld_data});
        end else begin
          hist.delete();
          m_dl = 1;
          m_last_addr = int'(ld_addr);
        end
      end
    end
  end

  function automatic bit m_permit();
    bit zl, zh;
    zl = m_last_addr < 8192;
    zh = m_last_addr >= 131072 - 8192;
    return (!m_wp || m_armed) && !(zl && m_lo) && !(zh && m_hi);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0d exp %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_en && !done) begin
    check("R12", "data_load", data_load, m_dl);
    check("R3", "wp_active", wp_active, m_wp);
    check("R6", "id_active", id_active, m_id);
    check("R7", "boot_lock_lo", boot_lock_lo, m_lo);
    check("R7", "boot_lock_hi", boot_lock_hi, m_hi);
    check("R8", "pgm_permit", pgm_permit, m_permit());
    check("R9", "erase_permit", erase_permit, !(m_lo || m_hi));
  end

  task automatic ld(logic [16:0] a, logic [7:0] d);
    @(negedge clk); ld_valid = 1; ld_addr = a; ld_data = d;
    @(negedge clk); ld_valid = 0; #1;
  endtask

  task automatic pend();
    @(negedge clk); prog_end = 1;
    @(negedge clk); prog_end = 0; #1;
  endtask

  task automatic pfx();
    ld(17'h05555, 8'hAA); ld(17'h02AAA, 8'h55);
  endtask

  task automatic ext(logic [7:0] op);
    pfx(); ld(17'h05555, 8'h80); pfx(); ld(17'h05555, op);
  endtask

  task automatic page(logic [16:0] base);
    for (int i = 0; i < 4; i++) ld(base + 17'(i), 8'(i * 3 + 1));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1; #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp_en = 1; rst_n = 1; #1;
    // R1 reset state
    check("R1", "wp_active", wp_active, 0);
    check("R1", "id_active", id_active, 0);
    check("R1", "pgm_permit", pgm_permit, 1);
    check("R1", "erase_permit", erase_permit, 1);
    check("R1", "data_load", data_load, 0);
    // R12 plain data byte pulses
    ld(17'h00100, 8'h12);
    check("R12", "data_load pulse", data_load, 1);
    @(negedge clk); #1;
    check("R12", "data_load single", data_load, 0);
    // R6 identification mode
    pfx(); ld(17'h05555, 8'h90);
    check("R6", "id on", id_active, 1);
    check("R12", "cmd byte no pulse", data_load, 0);
    pfx(); ld(17'h05555, 8'hF0);
    check("R6", "id off", id_active, 0);
    // R2 upper address bits ignored in command bytes
    ld(17'h15555, 8'hAA); ld(17'h12AAA, 8'h55); ld(17'h05555, 8'h90);
    check("R2", "id via high addr", id_active, 1);
    pfx(); ld(17'h05555, 8'hF0);
    // R3 enable protection
    pfx(); ld(17'h05555, 8'hA0);
    page(17'h04000);
    check("R3", "permit armed", pgm_permit, 1);
    check("R3", "wp before end", wp_active, 0);
    pend();
    check("R3", "wp after end", wp_active, 1);
    // R4 unarmed page while protected
    page(17'h04080);
    check("R4", "permit unarmed", pgm_permit, 0);
    pend();
    pfx(); ld(17'h05555, 8'hA0); page(17'h04100);
    check("R4", "permit armed again", pgm_permit, 1);
    pend();
    check("R4", "permit after end", pgm_permit, 0);
    // R10 broken sequence
    pfx(); ld(17'h05555, 8'h33);
    check("R10", "bad opcode is data", data_load, 1);
    ld(17'h05555, 8'h90);
    check("R10", "opcode alone no id", id_active, 0);
    ld(17'h05555, 8'hAA); ld(17'h05555, 8'hAA);
    check("R10", "repeated key is data", data_load, 1);
    // R11 reset keeps protection, drops id
    pfx(); ld(17'h05555, 8'h90);
    pfx();
    do_reset();
    check("R11", "wp kept", wp_active, 1);
    check("R11", "id cleared", id_active, 0);
    ld(17'h05555, 8'hA0);
    check("R11", "partial seq dropped", data_load, 1);
    // R5 disable protection
    ext(8'h20); page(17'h04200);
    check("R5", "permit during", pgm_permit, 1);
    check("R5", "wp before end", wp_active, 1);
    pend();
    check("R5", "wp cleared", wp_active, 0);
    // R7 lower lock, wrong byte first
    ext(8'h40); ld(17'h00005, 8'h00);
    check("R7", "wrong lock addr", boot_lock_lo, 0);
    ext(8'h40); ld(17'h00000, 8'h00);
    check("R7", "lock lo", boot_lock_lo, 1);
    check("R9", "erase blocked", erase_permit, 0);
    ld(17'h00010, 8'h5A);
    check("R8", "lo block denied", pgm_permit, 0);
    ld(17'h08000, 8'h5A);
    check("R8", "mid allowed", pgm_permit, 1);
    ext(8'h40); ld(17'h1FFFE, 8'hFF);
    check("R7", "wrong hi addr", boot_lock_hi, 0);
    ext(8'h40); ld(17'h1FFFF, 8'hFF);
    check("R7", "lock hi", boot_lock_hi, 1);
    ld(17'h1FF00, 8'h11);
    check("R8", "hi block denied", pgm_permit, 0);
    ld(17'h1DFFF, 8'h11);
    check("R8", "below hi block", pgm_permit, 1);
    do_reset();
    check("R11", "locks kept lo", boot_lock_lo, 1);
    check("R11", "locks kept hi", boot_lock_hi, 1);
    repeat (4) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1; n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule